// File: doc/BRIEF.md
# Interpolation Phase Controller

This block steers a bank of parallel cubic interpolators in a symbol-timing recovery loop. Each clock it adds a signed phase step, supplied by the loop filter, to an internal phase word. The low bits of the corrected phase are the fractional interval handed to the interpolators, and its top bits address their coefficient tables. When the sum overflows past one whole sample, a ten-state ring moves the interpolation window one sample later. When the sum drops below zero, the ring moves the window one sample earlier. The phase then returns to the unit interval.

The interpolation basepoints of every channel are fixed. They are produced as constants and never recomputed. Channel n uses samples 8n+1, 8n+3 and 8n+5 relative to the window start.

The phase step is not a stream. The controller accepts a new step on every clock in which `en` is high, so there is no back-pressure. When `en` is low the controller freezes: the step is ignored and every output holds.

Top module: `interp_phase_ctrl`

## Requirements
- R1: With `en` high, `mu` at the next clock equals (previous `mu` + `step`) modulo 2^32. `step` is signed Q2.32 (34 bits, 32 fraction bits, two's complement) with magnitude below 1.0.
- R2: With `en` high and previous phase + `step` in [0, 1.0), `win_ofs` keeps its value.
- R3: With `en` high and previous phase + `step` >= 1.0 (including exactly 1.0), `win_ofs` advances by one. From 9 it wraps to 0.
- R4: With `en` high and previous phase + `step` < 0, `win_ofs` steps back by one. From 0 it wraps to 9.
- R5: With `en` low, `step` is ignored, and `mu`, `coef_idx` and `win_ofs` hold their values.
- R6: Reset is synchronous and active-low (`rst_n`). It sets `mu` to 0 and `win_ofs` to 0 regardless of `en`.
- R7: `coef_idx` always equals bits 31:22 of `mu`.
- R8: `base_pts` carries 3 fields of 7 bits per channel. Field k (k = 0, 1, 2) of channel n (n = 0 to 15) sits at bits [(3n+k)*7 +: 7] and holds the constant 8n+2k+1.
- R9: `win_ofs` only takes values 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Loop enable; the step is applied when high |
| step | input | 34 | Signed Q2.32 phase increment from the loop filter |
| mu | output | 32 | Fractional interval (phase, unsigned 0.32) |
| coef_idx | output | 10 | Coefficient table index, top bits of `mu` |
| win_ofs | output | 4 | Window offset state, 0 to 9 |
| base_pts | output | 336 | Fixed basepoints, 16 channels x 3 points x 7 bits |

## Verification
The bench builds the block with its default parameters: 16 channels, stride 8, ten window states, a 32-bit fraction and a 10-bit table index. With these values the sum landing exactly on 1.0, a one-LSB underflow, the wrap of the ring in both directions and the largest basepoint (125, the full 7-bit field) can all be reached from a few hand-picked steps. Long runs with a constant positive step and a constant negative step then show the advance rate and the ramp of the fractional interval against an arithmetic model.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  // Where the phase sum lands relative to the unit interval
  typedef enum logic [1:0] {
    RG_MID  = 2'd0,  // 0 <= sum < 1
    RG_HIGH = 2'd1,  // sum >= 1
    RG_LOW  = 2'd2   // sum < 0
  } region_e;
endpackage

// File: rtl/ipc_phase_acc.sv
module ipc_phase_acc
  import ipc_pkg::*;
#(
  parameter int FRAC_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [FRAC_W+1:0] step,
  output logic [FRAC_W-1:0]        frac,
  output region_e                  region
);
  localparam int ACC_W = FRAC_W + 2;

  logic signed [ACC_W-1:0] eta_q;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] corr;

  always_comb begin
    sum = eta_q + step;
    if (sum[ACC_W-1])      region = RG_LOW;
    else if (sum[FRAC_W])  region = RG_HIGH;
    else                   region = RG_MID;
    // Adding or removing one whole unit leaves the fraction bits untouched
    corr = {{(ACC_W-FRAC_W){1'b0}}, sum[FRAC_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  eta_q <= '0;
    else if (en) eta_q <= corr;
  end

  assign frac = eta_q[FRAC_W-1:0];
endmodule

// File: rtl/ipc_win_fsm.sv
module ipc_win_fsm
  import ipc_pkg::*;
#(
  parameter int NSTATE = 10,
  parameter int SW     = $clog2(NSTATE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  region_e       region,
  output logic [SW-1:0] ofs
);
  localparam logic [SW-1:0] LAST = SW'(NSTATE - 1);

  logic [SW-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (region)
      RG_HIGH: st_d = (st_q == LAST) ? '0 : st_q + 1'b1;
      RG_LOW:  st_d = (st_q == '0) ? LAST : st_q - 1'b1;
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  st_q <= '0;
    else if (en) st_q <= st_d;
  end

  assign ofs = st_q;
endmodule

// File: rtl/ipc_base_gen.sv
module ipc_base_gen #(
  parameter int NCH    = 16,
  parameter int STRIDE = 8,
  parameter int NPT    = 3,
  parameter int BPW    = 7
) (
  output logic [NCH*NPT*BPW-1:0] base_pts
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    for (genvar k = 0; k < NPT; k++) begin : g_pt
      assign base_pts[(ch*NPT+k)*BPW +: BPW] = BPW'(STRIDE*ch + 2*k + 1);
    end
  end
endmodule

// File: rtl/interp_phase_ctrl.sv
module interp_phase_ctrl
  import ipc_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int STRIDE = 8,
  parameter int NSTATE = 10,
  parameter int FRAC_W = 32,
  parameter int TBL_W  = 10
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    en,
  input  logic signed [FRAC_W+1:0]                step,
  output logic [FRAC_W-1:0]                       mu,
  output logic [TBL_W-1:0]                        coef_idx,
  output logic [$clog2(NSTATE)-1:0]               win_ofs,
  output logic [NCH*3*$clog2(STRIDE*(NCH-1)+6)-1:0] base_pts
);
  localparam int SW     = $clog2(NSTATE);
  localparam int NPT    = 3;
  localparam int BP_MAX = STRIDE*(NCH-1) + 2*NPT - 1;
  localparam int BPW    = $clog2(BP_MAX + 1);

  region_e rgn;

  ipc_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step),
    .frac(mu), .region(rgn)
  );

  ipc_win_fsm #(.NSTATE(NSTATE), .SW(SW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .region(rgn), .ofs(win_ofs)
  );

  ipc_base_gen #(.NCH(NCH), .STRIDE(STRIDE), .NPT(NPT), .BPW(BPW)) u_base (
    .base_pts(base_pts)
  );

  assign coef_idx = mu[FRAC_W-1 -: TBL_W];
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
  import ipc_pkg::*;
#(
  parameter int FRAC_W = 32,
  parameter int NSTATE = 10,
  parameter int SW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [FRAC_W-1:0] step_lo,
  input logic [FRAC_W-1:0] mu,
  input logic [SW-1:0]     win_ofs,
  input region_e           region
);
  localparam logic [SW-1:0] LAST = SW'(NSTATE - 1);

  a_r1_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> mu == FRAC_W'($past(mu) + $past(step_lo)));

  a_r2_mid_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (en && region == RG_MID) |=> win_ofs == $past(win_ofs));

  a_r3_high_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (en && region == RG_HIGH) |=>
      win_ofs == (($past(win_ofs) == LAST) ? '0 : SW'($past(win_ofs) + 1'b1)));

  a_r4_low_retreats: assert property (@(posedge clk) disable iff (!rst_n)
    (en && region == RG_LOW) |=>
      win_ofs == (($past(win_ofs) == '0) ? LAST : SW'($past(win_ofs) - 1'b1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(mu) && $stable(win_ofs)));

  a_r6_reset: assert property (@(posedge clk)
    !rst_n |=> (mu == '0 && win_ofs == '0));

  a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
    win_ofs <= LAST);
endmodule

bind interp_phase_ctrl ipc_checker #(
  .FRAC_W(FRAC_W), .NSTATE(NSTATE), .SW(SW)
) u_ipc_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .step_lo(step[FRAC_W-1:0]),
  .mu(mu), .win_ofs(win_ofs), .region(rgn)
);

// File: tb/test_interp_phase_ctrl.sv
`timescale 1ns/1ps
module test_interp_phase_ctrl;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b0;
  logic signed [33:0] step = '0;
  logic [31:0]        mu;
  logic [9:0]         coef_idx;
  logic [3:0]         win_ofs;
  logic [335:0]       base_pts;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  longint m_eta;
  int     m_st;

  always #10 clk = ~clk;

  interp_phase_ctrl i_interp_phase_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step),
    .mu(mu), .coef_idx(coef_idx), .win_ofs(win_ofs), .base_pts(base_pts)
  );

  typedef struct packed {
    logic        en;
    logic [33:0] w;
    logic [31:0] mu;
    logic [3:0]  st;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b1, 34'h0_4000_0000, 32'h4000_0000, 4'd0},
    '{1'b1, 34'h0_4000_0000, 32'h8000_0000, 4'd0},
    '{1'b1, 34'h0_4000_0000, 32'hC000_0000, 4'd0},
    '{1'b1, 34'h0_4000_0000, 32'h0000_0000, 4'd1},  // sum exactly 1.0
    '{1'b0, 34'h0_4000_0000, 32'h0000_0000, 4'd1},  // disabled
    '{1'b1, 34'h3_C000_0000, 32'hC000_0000, 4'd0},  // -0.25 underflow
    '{1'b1, 34'h3_C000_0000, 32'h8000_0000, 4'd0},
    '{1'b1, 34'h3_8000_0000, 32'h0000_0000, 4'd0},  // lands on 0
    '{1'b1, 34'h3_FFFF_FFFF, 32'hFFFF_FFFF, 4'd9},  // 0 -> 9 wrap
    '{1'b1, 34'h0_0000_0001, 32'h0000_0000, 4'd0},  // 9 -> 0 wrap
    '{1'b1, 34'h0_FFFF_FFFF, 32'hFFFF_FFFF, 4'd0},
    '{1'b0, 34'h3_8000_0000, 32'hFFFF_FFFF, 4'd0},  // disabled
    '{1'b1, 34'h0_8000_0000, 32'h7FFF_FFFF, 4'd1}
  };

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // One clock: inputs set at negedge, outputs sampled at the following negedge
  task automatic tick(input logic e, input logic [33:0] w);
    en   = e;
    step = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_step(input logic e, input logic [33:0] w);
    longint s;
    if (e) begin
      s = m_eta + longint'($signed(w));
      if (s >= 64'sh1_0000_0000) begin
        s -= 64'sh1_0000_0000; m_st = (m_st + 1) % 10;
      end else if (s < 0) begin
        s += 64'sh1_0000_0000; m_st = (m_st + 9) % 10;
      end
      m_eta = s;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(1'b1, 34'h0_8000_0000);
    rst_n = 1'b1;
    m_eta = 0;
    m_st  = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R6: reset wins over en with a nonzero step
    do_reset();
    chk("R6", "mu after reset", mu, 0);
    chk("R6", "win_ofs after reset", win_ofs, 0);

    // Vector table
    for (int i = 0; i < 13; i++) begin
      int prev;
      prev = win_ofs;
      tick(VEC[i].en, VEC[i].w);
      chk("R1", "mu", mu, VEC[i].mu);
      chk("R7", "coef_idx", coef_idx, VEC[i].mu[31:22]);
      if (!VEC[i].en)                        chk("R5", "win_ofs", win_ofs, VEC[i].st);
      else if (VEC[i].st == (prev + 1) % 10) chk("R3", "win_ofs", win_ofs, VEC[i].st);
      else if (VEC[i].st == (prev + 9) % 10) chk("R4", "win_ofs", win_ofs, VEC[i].st);
      else                                   chk("R2", "win_ofs", win_ofs, VEC[i].st);
    end

    // R6: reset in the middle of a run
    do_reset();
    chk("R6", "mu after mid-run reset", mu, 0);
    chk("R6", "win_ofs after mid-run reset", win_ofs, 0);

    // R1/R3: constant positive step of about 0.2 (fractional ramp and advance rate)
    for (int i = 0; i < 60; i++) begin
      tick(1'b1, 34'h0_3333_3333);
      model_step(1'b1, 34'h0_3333_3333);
      chk("R1", "ramp mu", mu, m_eta);
      chk("R3", "ramp win_ofs", win_ofs, m_st);
      chk("R9", "win_ofs range", win_ofs < 10, 1);
    end
    // 60 x 0x33333333 = 11.99.. units: 11 advances from 0
    chk("R3", "advance count after 60 steps", win_ofs, 1);

    // R1/R4: constant negative step of about -0.1
    for (int i = 0; i < 60; i++) begin
      tick(1'b1, 34'h3_E666_6666);
      model_step(1'b1, 34'h3_E666_6666);
      chk("R1", "down ramp mu", mu, m_eta);
      chk("R4", "down ramp win_ofs", win_ofs, m_st);
      chk("R9", "win_ofs range", win_ofs < 10, 1);
    end

    // R5: a burst of large steps while disabled changes nothing
    begin
      logic [31:0] mu0;
      logic [3:0]  st0;
      mu0 = mu;
      st0 = win_ofs;
      for (int i = 0; i < 5; i++) tick(1'b0, 34'h0_FFFF_FFFF);
      chk("R5", "mu held", mu, mu0);
      chk("R5", "win_ofs held", win_ofs, st0);
      chk("R7", "coef_idx held", coef_idx, mu0[31:22]);
    end

    // R8: fixed basepoints
    for (int n = 0; n < 16; n++)
      for (int k = 0; k < 3; k++)
        chk("R8", "basepoint", base_pts[(3*n+k)*7 +: 7], 8*n + 2*k + 1);

    finish_run();
  end
endmodule